// File: doc/BRIEF.md
# Triggered Capture Sequencer

This block decides which converter samples go into a sample memory, and at which addresses they are written. It runs on one system clock. A one-cycle strobe marks each new word from the converter. The block also removes the converter's pipeline delay: the words that come out while the pipeline is still filling are discarded.

The block has two capture modes:

- **Posttrigger mode.** The block waits for a trigger edge. It then stores a programmed number of words and stops.
- **Pretrigger mode.** The block first fills a region of memory whose length is the programmed history count. It then keeps overwriting that region as a ring until a trigger edge arrives. After the trigger it appends the programmed number of further words directly behind the ring. When the capture ends, it reports the ring position of the oldest history word. Software reads the ring from that position onward, then reads the posttrigger area, and gets the samples in time order.

Top module: `acq_capture_ctrl`

## Requirements
- R1: With `pre_mode` = 0 (posttrigger), nothing is written before a trigger edge is accepted. After that, exactly `post_scans` words are written to addresses 0, 1, ... `post_scans`-1 in arrival order, and then writing stops.
- R2: With `pre_mode` = 1 (pretrigger), the first `pre_scans` stored words go to addresses 0 to `pre_scans`-1. No trigger is accepted before the last of them has been written. A trigger edge that occurs earlier is not remembered, and a trigger level still held high when the fill completes does not count.
- R3: After the fill, pretrigger words keep wrapping through addresses 0 to `pre_scans`-1, and each one replaces the oldest word in the ring.
- R4: After a trigger is accepted in pretrigger mode, `post_scans` further words are written to addresses `pre_scans` to `pre_scans`+`post_scans`-1 in order, and then writing stops. The ring is never written again.
- R5: `trig_loc` gives the ring address of the oldest history word at the moment of the trigger, which is where the next history word would have gone. In posttrigger mode it reads 0.
- R6: `acq_done` is a one-cycle pulse that occurs in the same cycle as the final memory write. That final write is the one that brings the count of remaining points to zero.
- R7: The words presented with the first 2 (`PIPE_LAT`) strobes after a start are never stored.
- R8: `busy` is high from the cycle after an accepted start until the cycle of `acq_done`. A `start` that arrives while `busy` is high is ignored, and so are the mode and counts presented with it.
- R9: Only a rising edge of `trig` is accepted, and only the first qualifying edge. In pretrigger mode, a strobe in the same cycle as the accepted edge still counts as a history word. In posttrigger mode, that strobe's word is not stored.
- R10: Each write takes place one cycle after its strobe: `mem_we` is high and `mem_wdata` carries the `scan_data` that was presented with that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a capture (taken only when idle) |
| pre_mode | input | 1 | 1 = pretrigger mode, 0 = posttrigger mode; sampled at start |
| pre_scans | input | CNT_W | History length, 1 or more; sampled at start |
| post_scans | input | CNT_W | Words stored after trigger, 1 or more; sampled at start |
| scan_stb | input | 1 | One-cycle pulse: new converter word present |
| scan_data | input | DATA_W | Converter output word |
| trig | input | 1 | Trigger level; its rising edge is used |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | CNT_W+1 | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| acq_done | output | 1 | End-of-capture pulse |
| busy | output | 1 | Capture in progress |
| trig_loc | output | CNT_W | Ring address of oldest history word |

## Verification
The hardest situation to reach from the ports is a trigger edge that falls right at a state boundary. Three such cases are checked:

- **Edge during the fill, level held past the end of the fill.** The edge comes in while the ring is still filling, and `trig` stays high until after the last fill word is written.
- **Edge in the same cycle as a strobe.** This is the cycle where the two modes treat the word differently.
- **Capture started without waiting for the pipeline.** The capture begins before the converter's pipeline has primed.

The bench sweeps several settings. It varies the history length, the post count and the number of extra ring laps. It places the trigger either alone or together with a strobe. It also includes a dedicated run that holds the trigger level across the end of the fill.

Every word carries its strobe index. This lets the bench rebuild the expected memory image and the expected `trig_loc` arithmetically from the number of strobes issued before the trigger.

// File: rtl/acq_pkg.sv
// Shared types for the triggered capture sequencer.
package acq_pkg;
    // Capture phase of the sequencer.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_ARMED = 2'd2,
        ST_POST  = 2'd3
    } acq_state_t;
endpackage

// File: rtl/acq_prime.sv
// Pipeline priming gate.
// Passes a strobe on only after LAT strobes have been seen since the last
// restart. Assumes the converter output lags its strobe by exactly LAT strobes.
module acq_prime #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic stb,
    output logic vstb
);
    generate
        if (LAT == 0) begin : g_nolat
            assign vstb = stb;
        end else begin : g_lat
            localparam int CW = $clog2(LAT + 1);
            localparam logic [CW-1:0] LAT_V = CW'(LAT);
            logic [CW-1:0] seen;

            // Count strobes up to LAT, then saturate.
            always_ff @(posedge clk) begin
                if (!rst_n)                      seen <= '0;
                else if (restart)                seen <= '0;
                else if (stb && seen != LAT_V)   seen <= seen + 1'b1;
            end

            assign vstb = stb && (seen == LAT_V);
        end
    endgenerate
endmodule

// File: rtl/acq_edge.sv
// Trigger edge qualifier.
// Reports a rising edge of lvl only while en is high. An edge seen while en is
// low is dropped and not remembered. Assumes lvl is already synchronous to clk.
module acq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic en,
    output logic accept
);
    logic lvl_q;

    // Remember the previous level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    assign accept = en && lvl && !lvl_q;
endmodule

// File: rtl/acq_down_cnt.sv
// Remaining-points down-counter.
// Loaded with a count, decremented once per stored word. last marks that the
// next decrement reaches zero. Assumes a loaded value of at least 1.
module acq_down_cnt #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last
);
    logic [W-1:0] cnt;

    // Load takes priority over decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (load)              cnt <= load_val;
        else if (dec && cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign last = (cnt == W'(1));
endmodule

// File: rtl/acq_ring_ptr.sv
// Ring address pointer.
// Counts 0 .. len-1 and wraps. ptr_next shows the value after one advance.
// Assumes len is at least 1 and stable while the pointer advances.
module acq_ring_ptr #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         adv,
    input  logic [W-1:0] len,
    output logic [W-1:0] ptr,
    output logic [W-1:0] ptr_next
);
    assign ptr_next = (ptr == len - 1'b1) ? '0 : ptr + 1'b1;

    // Move the pointer around the ring.
    always_ff @(posedge clk) begin
        if (!rst_n)     ptr <= '0;
        else if (clear) ptr <= '0;
        else if (adv)   ptr <= ptr_next;
    end
endmodule

// File: rtl/acq_capture_ctrl.sv
// Triggered capture sequencer (top).
// Steers converter words into a sample memory, in posttrigger mode or in
// pretrigger ring mode. Assumes scan_stb is a one-cycle pulse on clk, that trig
// is synchronous to clk, and that both counts are at least 1.
module acq_capture_ctrl
    import acq_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int CNT_W    = 24,
    parameter int PIPE_LAT = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                pre_mode,
    input  logic [CNT_W-1:0]    pre_scans,
    input  logic [CNT_W-1:0]    post_scans,
    input  logic                scan_stb,
    input  logic [DATA_W-1:0]   scan_data,
    input  logic                trig,
    output logic                mem_we,
    output logic [CNT_W:0]      mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                acq_done,
    output logic                busy,
    output logic [CNT_W-1:0]    trig_loc
);
    localparam int ADDR_W = CNT_W + 1;

    acq_state_t        state;
    logic              mode_q;
    logic [CNT_W-1:0]  pre_len;
    logic [CNT_W-1:0]  post_len;
    logic [ADDR_W-1:0] post_addr;

    logic              start_ok;
    logic              vstb;
    logic              trig_acc;
    logic              cnt_load;
    logic [CNT_W-1:0]  cnt_val;
    logic              cnt_dec;
    logic              cnt_last;
    logic              ring_adv;
    logic [CNT_W-1:0]  ptr;
    logic [CNT_W-1:0]  ptr_next;

    assign busy     = (state != ST_IDLE);
    assign start_ok = start && !busy;

    // Control terms for the counter and the ring pointer.
    always_comb begin
        cnt_load = start_ok || trig_acc;
        cnt_val  = start_ok ? pre_scans : post_len;
        cnt_dec  = vstb && (state == ST_FILL || state == ST_POST);
        ring_adv = vstb && (state == ST_FILL || (state == ST_ARMED && mode_q));
    end

    acq_prime #(.LAT(PIPE_LAT)) i_prime (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start_ok),
        .stb     (scan_stb),
        .vstb    (vstb)
    );

    acq_edge i_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl    (trig),
        .en     (state == ST_ARMED),
        .accept (trig_acc)
    );

    acq_down_cnt #(.W(CNT_W)) i_remain (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .last     (cnt_last)
    );

    acq_ring_ptr #(.W(CNT_W)) i_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start_ok),
        .adv      (ring_adv),
        .len      (pre_len),
        .ptr      (ptr),
        .ptr_next (ptr_next)
    );

    // Phase sequencing, memory write port and trigger location.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            mode_q    <= 1'b0;
            pre_len   <= '0;
            post_len  <= '0;
            post_addr <= '0;
            trig_loc  <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            acq_done  <= 1'b0;
        end else begin
            mem_we   <= 1'b0;
            acq_done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_ok) begin
                        mode_q   <= pre_mode;
                        pre_len  <= pre_scans;
                        post_len <= post_scans;
                        state    <= pre_mode ? ST_FILL : ST_ARMED;
                    end
                end
                ST_FILL: begin
                    if (vstb) begin
                        mem_we    <= 1'b1;
                        mem_addr  <= {1'b0, ptr};
                        mem_wdata <= scan_data;
                        if (cnt_last) state <= ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (vstb && mode_q) begin
                        mem_we    <= 1'b1;
                        mem_addr  <= {1'b0, ptr};
                        mem_wdata <= scan_data;
                    end
                    if (trig_acc) begin
                        post_addr <= mode_q ? {1'b0, pre_len} : '0;
                        if (mode_q) trig_loc <= vstb ? ptr_next : ptr;
                        else        trig_loc <= '0;
                        state <= ST_POST;
                    end
                end
                ST_POST: begin
                    if (vstb) begin
                        mem_we    <= 1'b1;
                        mem_addr  <= post_addr;
                        mem_wdata <= scan_data;
                        post_addr <= post_addr + 1'b1;
                        if (cnt_last) begin
                            acq_done <= 1'b1;
                            state    <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/acq_capture_chk.sv
// Property checker for the triggered capture sequencer, bound to the top.
module acq_capture_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             scan_stb,
    input logic             mem_we,
    input logic             acq_done,
    input logic             busy,
    input logic             mode_q,
    input logic [CNT_W-1:0] pre_len,
    input logic [CNT_W-1:0] trig_loc
);
    // R6
    done_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acq_done |-> mem_we);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acq_done |=> !acq_done);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acq_done |-> !busy);

    // R10
    write_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(scan_stb));

    // R8
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R8
    write_in_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (busy || acq_done));

    // R5
    trig_loc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_done && mode_q) |-> (trig_loc < pre_len));
endmodule

bind acq_capture_ctrl acq_capture_chk #(.CNT_W(CNT_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .scan_stb (scan_stb),
    .mem_we   (mem_we),
    .acq_done (acq_done),
    .busy     (busy),
    .mode_q   (mode_q),
    .pre_len  (pre_len),
    .trig_loc (trig_loc)
);

// File: tb/test_acq_capture_ctrl.sv
// Bench for the triggered capture sequencer: sweeps small settings and
// rebuilds the expected memory image from strobe indices.
module test_acq_capture_ctrl;
    localparam int DW = 8;
    localparam int CW = 8;
    localparam int LAT = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          pre_mode = 1'b0;
    logic [CW-1:0] pre_scans = '0;
    logic [CW-1:0] post_scans = '0;
    logic          scan_stb = 1'b0;
    logic [DW-1:0] scan_data = '0;
    logic          trig = 1'b0;
    logic          mem_we;
    logic [CW:0]   mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          acq_done;
    logic          busy;
    logic [CW-1:0] trig_loc;

    int nchk = 0;
    int nerr = 0;
    int sidx = 0;
    int nwr = 0;
    int ndone = 0;
    int done_wr = 0;
    int done_addr = 0;
    logic [DW-1:0] img [0:63];

    always #2 clk = ~clk;

    acq_capture_ctrl #(.DATA_W(DW), .CNT_W(CW), .PIPE_LAT(LAT)) i_acq_capture_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .pre_mode(pre_mode),
        .pre_scans(pre_scans), .post_scans(post_scans), .scan_stb(scan_stb),
        .scan_data(scan_data), .trig(trig), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .acq_done(acq_done), .busy(busy), .trig_loc(trig_loc)
    );

    // Record memory writes and end pulses away from the active edge.
    always @(negedge clk) begin
        if (mem_we) begin
            nwr <= nwr + 1;
            if (mem_addr < 64) img[mem_addr] <= mem_wdata;
        end
        if (acq_done) begin
            ndone <= ndone + 1;
            done_wr <= int'(mem_we);
            done_addr <= int'(mem_addr);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    task automatic do_start(input logic m, input int pre, input int post);
        @(negedge clk);
        nwr = 0; ndone = 0;
        for (int i = 0; i < 64; i++) img[i] = 8'hFF;
        start = 1'b1; pre_mode = m; pre_scans = CW'(pre); post_scans = CW'(post);
        @(negedge clk);
        start = 1'b0;
        sidx = 0;
    endtask

    task automatic strobe(input logic with_trig);
        @(negedge clk);
        scan_stb = 1'b1; scan_data = DW'(sidx); trig = with_trig;
        @(negedge clk);
        scan_stb = 1'b0; trig = 1'b0;
        sidx++;
    endtask

    task automatic pulse_trig();
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
    endtask

    task automatic run_out();
        for (int g = 0; g < 300 && busy; g++) strobe(1'b0);
        @(negedge clk);
    endtask

    // Compare a completed pretrigger capture; s = strobes up to the trigger.
    task automatic check_pre(input int pre, input int post, input int s);
        int v;
        v = s - LAT;
        chk("R3 write count", nwr, v + post);
        chk("R5 trig_loc", int'(trig_loc), v % pre);
        for (int i = 0; i < pre; i++)
            chk("R3 ring oldest-first", int'(img[(v + i) % pre]), v - pre + i + LAT);
        for (int j = 0; j < post; j++)
            chk("R4 post area", int'(img[pre + j]), s + j);
        chk("R6 single done", ndone, 1);
        chk("R6 done with write", done_wr, 1);
        chk("R6 done at last addr", done_addr, pre + post - 1);
        chk("R8 busy low after done", int'(busy), 0);
    endtask

    task automatic check_post(input int post, input int first);
        chk("R1 write count", nwr, post);
        for (int j = 0; j < post; j++)
            chk("R1 R7 R10 post data", int'(img[j]), first + j);
        chk("R5 trig_loc post mode", int'(trig_loc), 0);
        chk("R6 single done", ndone, 1);
        chk("R6 done at last addr", done_addr, post - 1);
        chk("R8 busy low after done", int'(busy), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 reset busy", int'(busy), 0);
        chk("R10 reset mem_we", int'(mem_we), 0);
        chk("R6 reset acq_done", int'(acq_done), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R7 R9: posttrigger sweep over count, trigger position and same-cycle strobe.
        for (int post = 1; post <= 4; post++)
            for (int t = 0; t <= 4; t++)
                for (int same = 0; same <= 1; same++) begin
                    do_start(1'b0, 3, post);
                    chk("R8 busy after start", int'(busy), 1);
                    for (int k = 0; k < t; k++) strobe(1'b0);
                    chk("R1 nothing before trigger", nwr, 0);
                    if (same == 1) strobe(1'b1);
                    else pulse_trig();
                    run_out();
                    check_post(post, (same == 1) ? ((t + 1 > LAT) ? t + 1 : LAT)
                                                 : ((t > LAT) ? t : LAT));
                end

        // R2 R3 R4 R9: pretrigger sweep over history, post count, laps and same-cycle strobe.
        for (int pre = 1; pre <= 4; pre++)
            for (int post = 1; post <= 3; post++)
                for (int extra = 0; extra <= 2; extra++)
                    for (int same = 0; same <= 1; same++) begin
                        int s;
                        s = LAT + pre + extra + same;
                        do_start(1'b1, pre, post);
                        for (int k = 0; k < s - same; k++) strobe(1'b0);
                        if (same == 1) strobe(1'b1);
                        else pulse_trig();
                        run_out();
                        check_pre(pre, post, s);
                    end

        // R2 R9: early edge dropped, level held across end of fill not taken.
        do_start(1'b1, 3, 2);
        for (int k = 0; k < 3; k++) strobe(1'b0);
        pulse_trig();
        strobe(1'b0);
        @(negedge clk); trig = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); scan_stb = 1'b1; scan_data = DW'(sidx);
            @(negedge clk); scan_stb = 1'b0; sidx++;
        end
        trig = 1'b0;
        chk("R2 no end while trigger ignored", ndone, 0);
        chk("R2 still busy", int'(busy), 1);
        strobe(1'b0);
        pulse_trig();
        run_out();
        check_pre(3, 2, 8);

        // R8: start while busy is ignored, mode and counts unchanged.
        do_start(1'b1, 2, 2);
        for (int k = 0; k < 5; k++) strobe(1'b0);
        @(negedge clk); start = 1'b1; pre_mode = 1'b0; pre_scans = 1; post_scans = 1;
        @(negedge clk); start = 1'b0;
        strobe(1'b0);
        pulse_trig();
        run_out();
        check_pre(2, 2, 6);

        summary();
    end
endmodule